// File: doc/BRIEF.md
# Two-Channel Interval Timer with Pulse-Width Output

This block holds two identical counter channels behind a small register port. Each channel can count up or down from a reload value. When it reaches its terminal value it can reload and keep running, or stop. Each terminal event raises a sticky interrupt flag and can emit a one-cycle pulse on that channel's generate output. A write that asserts the enable-all bit starts both channels on the same clock edge.

When both channels are set up for pulse-width mode, they work as a pair. Channel 0 sets the period, and each of its terminal events starts a new period and restarts channel 1. Channel 1 sets the high time. The output goes high when a period starts and drops when channel 1 expires.

Access is through a single-cycle port. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset, every register reads zero and the generate, interrupt and pulse-width outputs are low.
- R2: Registers sit at byte addresses as follows. Channel 0 uses 0x00 for control, 0x04 for the reload value and 0x08 for the read-only counter. Channel 1 uses 0x10, 0x14 and 0x18 for the same three registers. Control bits are:
  - bit 0: capture select (0 means generate)
  - bit 1: count down
  - bit 2: generate-output enable
  - bit 3: capture trigger
  - bit 4: auto-reload
  - bit 5: load
  - bit 6: interrupt enable
  - bit 7: run enable
  - bit 8: interrupt flag
  - bit 9: pulse-width enable
  - bit 10: enable-all strobe, which always reads 0
  - bit 11: cascade
- R3: While the load bit is 1, the counter takes the reload value on every cycle. Counting resumes, one step per cycle, once the load bit is cleared.
- R4: A down-counting channel with auto-reload has a terminal value of 0. It produces one terminal event every reload+2 cycles.
- R5: An up-counting channel with auto-reload has a terminal value of all-ones. It produces one terminal event every (2^CW-1)-reload+2 cycles.
- R6: Without auto-reload, a channel stops at its first terminal event. Hardware clears its run-enable bit and the counter holds the terminal value.
- R7: On a terminal event, the channel's generate output is high for exactly one cycle if generate-output enable is 1. Otherwise it stays low.
- R8: A terminal event sets the channel's flag bit. Writing 1 to the flag bit clears it, and writing 0 leaves it unchanged. The channel's interrupt output equals flag AND interrupt enable.
- R9: A control write to either channel with bit 10 set sets the run-enable bits of both channels on the same edge.
- R10: Pulse-width mode is active only when both channels meet all of these conditions:
  - capture select, load and cascade are all 0
  - pulse-width enable, generate-output enable, auto-reload and run enable are all 1
  
  While the mode is inactive, the pulse-width output is low.
- R11: In pulse-width mode, a channel 0 terminal event does three things: it starts a new period, drives the output high, and restarts channel 1 from its reload value. The output falls at channel 1's terminal event. The high time is channel 1's period and the full cycle is channel 0's period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| gen_o | output | 2 | Per-channel terminal pulse |
| irq_o | output | 2 | Per-channel interrupt request |
| pwm_o | output | 1 | Pulse-width output |

## Verification
The bench measures periods in both count directions, including the extreme reload values.

- **Up-count all-ones reload.** It must give a 2-cycle period. An off-by-one in the terminal hold cycle would give 1 or 3 cycles.
- **Pulse-width pairs.** The bench checks high time and full period for several pairs, among them a duty one cycle short of the period. A design that did not restart channel 1 at each period would drift in phase and report changing high times.
- **Cascade bit.** The bench confirms that setting cascade keeps the output low.
- **Load hold.** The bench confirms that the counter holds while load is set. A design that loaded only once would show a counter that has moved.
- **One-shot stop.** The bench confirms that a one-shot channel clears its run bit. A design without this would keep pulsing.

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [1:0]  gen_o,
  output logic [1:0]  irq_o,
  output logic        pwm_o
);
  localparam int B_CAPT = 0, B_DOWN = 1, B_GEN = 2, B_TRIG = 3, B_AR = 4, B_LD = 5;
  localparam int B_IE = 6, B_EN = 7, B_FLAG = 8, B_PW = 9, B_ALL = 10, B_CASC = 11;
  localparam logic [1:0] R_CTL = 2'd0, R_RLD = 2'd1, R_CNT = 2'd2;
  localparam logic [CW-1:0] ONES = '1;

  logic [11:0]   csr [2];
  logic [CW-1:0] rld [2];
  logic [CW-1:0] cnt [2];
  logic [1:0]    pend, wrap, run, at_term, wr_ctl, wr_rld, ok;
  logic          enall, pw_act, restart1, pwm_q;

  assign enall = wr_en && addr[3:2] == R_CTL && wdata[B_ALL];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      wr_ctl[i]  = wr_en && addr[4] == i[0] && addr[3:2] == R_CTL;
      wr_rld[i]  = wr_en && addr[4] == i[0] && addr[3:2] == R_RLD;
      run[i]     = csr[i][B_EN] && !csr[i][B_LD];
      wrap[i]    = run[i] && pend[i];
      at_term[i] = cnt[i] == (csr[i][B_DOWN] ? '0 : ONES);
      ok[i]      = !csr[i][B_CAPT] && csr[i][B_PW] && csr[i][B_GEN] && csr[i][B_AR]
                   && csr[i][B_EN] && !csr[i][B_LD] && !csr[i][B_CASC];
    end
  end

  assign pw_act   = &ok;
  assign restart1 = pw_act && wrap[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        csr[i] <= '0;
        rld[i] <= '0;
        cnt[i] <= '0;
      end
      pend  <= '0;
      pwm_q <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (wr_ctl[i]) begin
          csr[i][7:0]    <= wdata[7:0];
          csr[i][B_PW]   <= wdata[B_PW];
          csr[i][B_CASC] <= wdata[B_CASC];
        end
        if (enall)
          csr[i][B_EN] <= 1'b1;
        else if (!wr_ctl[i] && wrap[i] && !csr[i][B_AR])
          csr[i][B_EN] <= 1'b0;
        if (wrap[i])
          csr[i][B_FLAG] <= 1'b1;
        else if (wr_ctl[i] && wdata[B_FLAG])
          csr[i][B_FLAG] <= 1'b0;
        if (wr_rld[i])
          rld[i] <= wdata[CW-1:0];

        if (csr[i][B_LD]) begin
          cnt[i]  <= rld[i];
          pend[i] <= 1'b0;
        end else if (i == 1 && restart1) begin
          cnt[i]  <= rld[i];
          pend[i] <= 1'b0;
        end else if (run[i]) begin
          if (pend[i]) begin
            pend[i] <= 1'b0;
            if (csr[i][B_AR]) cnt[i] <= rld[i];
          end else if (at_term[i]) begin
            pend[i] <= 1'b1;
          end else begin
            cnt[i] <= csr[i][B_DOWN] ? cnt[i] - 1'b1 : cnt[i] + 1'b1;
          end
        end
      end

      if (!pw_act)      pwm_q <= 1'b0;
      else if (wrap[0]) pwm_q <= 1'b1;
      else if (wrap[1]) pwm_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr[3:2])
      R_CTL:   rdata = {20'd0, csr[addr[4]]};
      R_RLD:   rdata = 32'(rld[addr[4]]);
      R_CNT:   rdata = 32'(cnt[addr[4]]);
      default: rdata = '0;
    endcase
  end

  assign gen_o[0] = wrap[0] && csr[0][B_GEN];
  assign gen_o[1] = wrap[1] && csr[1][B_GEN];
  assign irq_o[0] = csr[0][B_FLAG] && csr[0][B_IE];
  assign irq_o[1] = csr[1][B_FLAG] && csr[1][B_IE];
  assign pwm_o    = pwm_q;

  // R3: load bit forces the reload value into the counter
  a_r3_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
    csr[0][B_LD] |=> cnt[0] == $past(rld[0]));
  // R4: one step per cycle while counting down
  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run[0] && !pend[0] && csr[0][B_DOWN] && cnt[0] != '0) |=> cnt[0] == $past(cnt[0]) - 1'b1);
  // R6: one-shot channel stops itself
  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap[0] && !csr[0][B_AR] && !wr_ctl[0] && !enall) |=> !csr[0][B_EN]);
  // R7: generate pulse lasts one cycle
  a_r7_gen_single: assert property (@(posedge clk) disable iff (!rst_n)
    gen_o[0] |=> !gen_o[0]);
  // R8: terminal event sets the flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |=> csr[1][B_FLAG]);
  // R9: enable-all starts both channels together
  a_r9_enall_both: assert property (@(posedge clk) disable iff (!rst_n)
    enall |=> (csr[0][B_EN] && csr[1][B_EN]));
  // R10: output low outside pulse-width mode
  a_r10_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_act |=> !pwm_o);
  // R11: output rises only at a channel 0 terminal event
  a_r11_rise_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(wrap[0]));
endmodule

// File: tb/dual_timer_pwm_tb.sv
module dual_timer_pwm_tb;
  localparam int CW = 8;
  localparam logic [4:0] C0 = 5'h00, L0 = 5'h04, N0 = 5'h08, C1 = 5'h10, L1 = 5'h14, N1 = 5'h18;
  localparam int DOWN = 1 << 1, GEN = 1 << 2, AR = 1 << 4, LD = 1 << 5, IE = 1 << 6;
  localparam int EN = 1 << 7, FLAG = 1 << 8, PW = 1 << 9, ALL = 1 << 10, CASC = 1 << 11;

  // period vectors: down, reload, expected period
  localparam int NP = 5;
  localparam int PV [NP][3] = '{'{1, 0, 2}, '{1, 5, 7}, '{0, 252, 5}, '{0, 255, 2}, '{1, 200, 202}};
  // pulse-width vectors: down, reload0, reload1, expected high, expected period
  localparam int NW = 4;
  localparam int WV [NW][5] = '{'{1, 10, 3, 5, 12}, '{1, 20, 0, 2, 22}, '{1, 6, 5, 7, 8}, '{0, 250, 253, 4, 7}};

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] gen_o, irq_o;
  logic pwm_o;
  int errors = 0, checks = 0;

  dual_timer_pwm #(.CW(CW)) u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gen_o(gen_o), .irq_o(irq_o), .pwm_o(pwm_o));

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [4:0] a, int d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output int d);
    addr = a; #1; d = rdata;
  endtask

  task automatic gen_period(output int p);
    int n = 0;
    p = -1;
    while (!gen_o[0] && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk); p = 1;
    while (!gen_o[0] && p < 2000) begin @(negedge clk); p++; end
  endtask

  task automatic pwm_measure(output int hi, output int per);
    int n = 0;
    logic prev = pwm_o;
    hi = 0; per = 0;
    while (!(pwm_o && !prev) && n < 2000) begin prev = pwm_o; @(negedge clk); n++; end
    while (pwm_o && hi < 2000) begin @(negedge clk); hi++; end
    per = hi;
    while (!pwm_o && per < 4000) begin @(negedge clk); per++; end
  endtask

  task automatic pwm_setup(int dn, int r0, int r1, int extra0);
    wr(L0, r0); wr(L1, r1);
    wr(C0, LD); wr(C1, LD);
    wr(C0, (dn ? DOWN : 0) | GEN | AR | PW | extra0);
    wr(C1, (dn ? DOWN : 0) | GEN | AR | PW | ALL);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int v, p, h, cnt;
    do_reset();
    // R1 and R2: reset values at every address
    rd(C0, v); check("R1 ctl0", v, 0);
    rd(L0, v); check("R1 rld0", v, 0);
    rd(N0, v); check("R1 cnt0", v, 0);
    rd(C1, v); check("R1 ctl1", v, 0);
    rd(L1, v); check("R1 rld1", v, 0);
    rd(N1, v); check("R1 cnt1", v, 0);
    check("R1 outputs", {27'd0, gen_o, irq_o, pwm_o}, 0);

    // R4 R5 R7: period vectors
    for (int k = 0; k < NP; k++) begin
      do_reset();
      wr(L0, PV[k][1]); wr(C0, LD);
      wr(C0, (PV[k][0] ? DOWN : 0) | GEN | AR | EN);
      gen_period(p);
      check(PV[k][0] ? "R4 down period" : "R5 up period", p, PV[k][2]);
    end

    // R11: pulse-width vectors
    for (int k = 0; k < NW; k++) begin
      do_reset();
      pwm_setup(WV[k][0], WV[k][1], WV[k][2], 0);
      pwm_measure(h, p);
      pwm_measure(h, p);
      check("R11 high time", h, WV[k][3]);
      check("R11 full period", p, WV[k][4]);
    end

    // R10: cascade bit blocks the output; gen still pulses
    do_reset();
    pwm_setup(1, 6, 2, CASC);
    cnt = 0; h = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); cnt += pwm_o; h += gen_o[0]; end
    check("R10 pwm stays low with cascade", cnt, 0);
    check("R7 gen pulses while pwm blocked", h > 0, 1);

    // R3: load holds, counting resumes after clear
    do_reset();
    wr(L0, 9); wr(C0, LD | EN | DOWN);
    repeat (5) @(negedge clk);
    rd(N0, v); check("R3 held under load", v, 9);
    wr(C0, EN | DOWN | AR);
    repeat (3) @(negedge clk);
    rd(N0, v); check("R3 resumes counting", v, 6);

    // R7: generate output silent when its enable is clear
    do_reset();
    wr(L0, 2); wr(C0, LD); wr(C0, DOWN | AR | EN);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); cnt += gen_o[0]; end
    check("R7 no pulse without enable", cnt, 0);

    // R6: one-shot stops and holds
    do_reset();
    wr(L0, 4); wr(C0, LD); wr(C0, DOWN | GEN | EN);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); cnt += gen_o[0]; end
    check("R6 single pulse", cnt, 1);
    rd(C0, v); check("R6 enable cleared", (v >> 7) & 1, 0);
    rd(N0, v); check("R6 counter holds terminal", v, 0);

    // R8: flag, interrupt, write-1-to-clear
    do_reset();
    wr(L0, 3); wr(C0, LD); wr(C0, DOWN | AR | EN | IE);
    repeat (10) @(negedge clk);
    rd(C0, v); check("R8 flag set", (v >> 8) & 1, 1);
    check("R8 irq raised", irq_o[0], 1);
    wr(C0, IE);
    rd(C0, v); check("R8 write 0 keeps flag", (v >> 8) & 1, 1);
    wr(C0, IE | FLAG);
    rd(C0, v); check("R8 flag cleared", (v >> 8) & 1, 0);
    check("R8 irq dropped", irq_o[0], 0);

    // R9: enable-all from channel 1 write
    do_reset();
    wr(C1, ALL);
    rd(C0, v); check("R9 ch0 enabled", (v >> 7) & 1, 1);
    rd(C1, v); check("R9 ch1 enabled", (v >> 7) & 1, 1);
    check("R2 enable-all reads zero", (v >> 10) & 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule